// File: doc/BRIEF.md
# Serial Signalling-Channel Contention Arbiter

This block decides which of up to 32 serial signalling channels of a time-division frame may use one shared HDLC receiver. The frame timing logic pulses `frame_stb` once per frame. On that clock the block samples the signalling bit of every enabled channel. A low bit means the channel wants to start sending. The lowest-numbered requester that is eligible gets the receiver. The grant holds until the receiver reports that the frame ended or was aborted.

Each channel also gets a status bit back: 1 means available and 0 means blocked. While one channel is being received, the others are told they are blocked. That status travels in one of two carriers, the command/indicate field or the monitor-receive bit, and a mode input picks which one.

Fairness works in two phases. After a grant is released, the channel that was just served may not compete. The other channels compete as usual during this limited phase. The limited phase ends, and every channel may compete again, after a programmable run of idle frames. The host can also freeze that idle counter and set the phase directly.

Top module: `dch_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, and `ind_ci` and `ind_mr` are all zeros.
- R2: In the full phase, when `frame_stb` is high and no grant is held, the arbiter grants the lowest channel index whose `chan_en` bit is 1 and whose `d_bits` bit is 0. It sets `grant_valid` to 1 and `grant_idx` to that index. A channel whose `chan_en` bit is 0 is never granted.
- R3: With `master_en` = 1, a frame strobe while a grant is held sets the status of the granted channel to 1 and the status of every other channel to 0. With no grant held, the status equals `chan_en`. Disabled channels always read 0.
- R4: With `master_en` = 0, the status of every channel equals `chan_en`, even while a grant is held.
- R5: At each frame strobe, `ind_in_mr` = 0 routes the status to `ind_ci` and holds `ind_mr` at all zeros. `ind_in_mr` = 1 does the reverse.
- R6: A grant ignores new requests and holds until `rx_done` has been seen. The release then takes effect at the next frame strobe, which clears `grant_valid` and grants nothing in that frame.
- R7: In the limited phase, the channel released last cannot be granted. Any other enabled channel can be granted.
- R8: With `susp_off` = 0 and `fsel_cnt` = N > 0, a release enters the limited phase. The N+1-th following strobe that finds no eligible request switches to the full phase. A request on that same strobe is judged under the limited rules.
- R9: With `fsel_cnt` = 0, a release enters the full phase directly, so the channel just served may be granted on the next strobe.
- R10: With `susp_off` = 1, the idle count has no effect. At a release, and at each strobe with no eligible request, the phase becomes full if `host_full` = 1 and limited if `host_full` = 0.
- R11: `grant_valid`, `grant_idx`, `ind_ci` and `ind_mr` change only on a clock edge where `frame_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| d_bits | input | NCH | Signalling bit of each channel, 0 = request |
| chan_en | input | NCH | Per-channel participation mask |
| fsel_cnt | input | 5 | Idle frames minus one before the full phase returns |
| susp_off | input | 1 | 1 = idle counter off, phase set by `host_full` |
| host_full | input | 1 | Phase chosen by the host when `susp_off` = 1 |
| ind_in_mr | input | 1 | 1 = status carried in the monitor-receive bit |
| master_en | input | 1 | 1 = send blocked status during reception |
| rx_done | input | 1 | Receiver end of frame or abort pulse |
| grant_valid | output | 1 | A channel holds the receiver |
| grant_idx | output | IW | Index of the granted channel |
| ind_ci | output | NCH | Per-channel status in the command/indicate field, 1 = available |
| ind_mr | output | NCH | Per-channel status in the monitor-receive bit, 1 = available |

## Verification
The hardest state to reach is the exact frame on which the limited phase turns into the full phase. Nothing at the ports shows the phase or the idle count. The stimulus therefore keeps presenting a request only on the channel just served. That request must stay refused through N+1 strobes and then win on the next one. Refusal one frame early or late shows up in `grant_valid`. The same method, with the counter frozen, shows that the host phase input overrides the idle count.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;
    typedef enum logic [1:0] {
        PH_FULL    = 2'd0,
        PH_LIMITED = 2'd1,
        PH_BUSY    = 2'd2
    } phase_e;
endpackage

// File: rtl/dch_lowest_pick.sv
module dch_lowest_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dch_ind_route.sv
module dch_ind_route #(
    parameter int N = 32
) (
    input  logic [N-1:0] avail,
    input  logic         to_mr,
    output logic [N-1:0] ci,
    output logic [N-1:0] mr
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign ci[g] = avail[g] & ~to_mr;
        assign mr[g] = avail[g] &  to_mr;
    end
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
    import dch_arb_pkg::*;
#(
    parameter int NCH = 32,
    parameter int CW  = 5,
    parameter int IW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_stb,
    input  logic [NCH-1:0] d_bits,
    input  logic [NCH-1:0] chan_en,
    input  logic [CW-1:0]  fsel_cnt,
    input  logic           susp_off,
    input  logic           host_full,
    input  logic           ind_in_mr,
    input  logic           master_en,
    input  logic           rx_done,
    output logic           grant_valid,
    output logic [IW-1:0]  grant_idx,
    output logic [NCH-1:0] ind_ci,
    output logic [NCH-1:0] ind_mr
);
    typedef struct packed {
        phase_e         phase;
        logic [CW-1:0]  idle_cnt;
        logic [IW-1:0]  last;
        logic [IW-1:0]  gidx;
        logic           gv;
        logic           pend;
        logic [NCH-1:0] avail;
        logic           to_mr;
    } arb_state_t;

    arb_state_t s_q, s_d;

    logic [NCH-1:0] last_oh;
    logic [NCH-1:0] grant_oh;
    logic [NCH-1:0] cand;
    logic           pick_found;
    logic [IW-1:0]  pick_idx;

    always_comb begin
        last_oh = '0;
        last_oh[s_q.last] = 1'b1;
        cand = chan_en & ~d_bits;
        if (s_q.phase == PH_LIMITED) begin
            cand = cand & ~last_oh;
        end
    end

    dch_lowest_pick #(.N(NCH), .IW(IW)) u_pick (
        .req   (cand),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        s_d = s_q;
        grant_oh = '0;
        if (rx_done && s_q.phase == PH_BUSY) begin
            s_d.pend = 1'b1;
        end
        if (frame_stb) begin
            s_d.pend  = 1'b0;
            s_d.to_mr = ind_in_mr;
            if (s_q.phase == PH_BUSY) begin
                if (s_q.pend || rx_done) begin
                    s_d.gv       = 1'b0;
                    s_d.last     = s_q.gidx;
                    s_d.idle_cnt = '0;
                    if (susp_off) begin
                        s_d.phase = host_full ? PH_FULL : PH_LIMITED;
                    end else begin
                        s_d.phase = (fsel_cnt == '0) ? PH_FULL : PH_LIMITED;
                    end
                end
            end else if (pick_found) begin
                s_d.gv    = 1'b1;
                s_d.gidx  = pick_idx;
                s_d.phase = PH_BUSY;
            end else if (susp_off) begin
                s_d.phase = host_full ? PH_FULL : PH_LIMITED;
            end else if (s_q.phase == PH_LIMITED) begin
                if (s_q.idle_cnt >= fsel_cnt) begin
                    s_d.phase = PH_FULL;
                end else begin
                    s_d.idle_cnt = s_q.idle_cnt + 1'b1;
                end
            end
            grant_oh[s_d.gidx] = 1'b1;
            if (master_en && s_d.gv) begin
                s_d.avail = chan_en & grant_oh;
            end else begin
                s_d.avail = chan_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FULL, idle_cnt: '0, last: '0, gidx: '0,
                     gv: 1'b0, pend: 1'b0, avail: '0, to_mr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    dch_ind_route #(.N(NCH)) u_route (
        .avail (s_q.avail),
        .to_mr (s_q.to_mr),
        .ci    (ind_ci),
        .mr    (ind_mr)
    );

    assign grant_valid = s_q.gv;
    assign grant_idx   = s_q.gidx;
endmodule

// File: rtl/dch_arbiter_chk.sv
module dch_arbiter_chk #(
    parameter int NCH = 32,
    parameter int IW  = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_stb,
    input logic [NCH-1:0] d_bits,
    input logic [NCH-1:0] chan_en,
    input logic           ind_in_mr,
    input logic           master_en,
    input logic           grant_valid,
    input logic [IW-1:0]  grant_idx,
    input logic [NCH-1:0] ind_ci,
    input logic [NCH-1:0] ind_mr
);
    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    assert_frame_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(grant_valid) && $stable(grant_idx)
                        && $stable(ind_ci) && $stable(ind_mr)));

    assert_carrier_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> ((ind_ci & ind_mr) == '0));

    assert_mr_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && ind_in_mr) |=> (ind_ci == '0));

    assert_single_avail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && master_en) |=>
            (!grant_valid || $countones(ind_ci | ind_mr) <= 1));

    assert_all_avail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !master_en) |=> ((ind_ci | ind_mr) == $past(chan_en)));

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !grant_valid) |=>
            (!grant_valid ||
             ((($past(chan_en) & ~$past(d_bits)) >> grant_idx) & ONE) != '0));
endmodule

bind dch_arbiter dch_arbiter_chk #(.NCH(NCH), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_stb   (frame_stb),
    .d_bits      (d_bits),
    .chan_en     (chan_en),
    .ind_in_mr   (ind_in_mr),
    .master_en   (master_en),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .ind_ci      (ind_ci),
    .ind_mr      (ind_mr)
);

// File: tb/tb_dch_arbiter.sv
module tb_dch_arbiter;
    localparam int NCH = 32;
    localparam int IW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_stb = 1'b0;
    logic [NCH-1:0] d_bits = '1;
    logic [NCH-1:0] chan_en = '1;
    logic [4:0]     fsel_cnt = 5'd2;
    logic           susp_off = 1'b0;
    logic           host_full = 1'b0;
    logic           ind_in_mr = 1'b0;
    logic           master_en = 1'b1;
    logic           rx_done = 1'b0;
    logic           grant_valid;
    logic [IW-1:0]  grant_idx;
    logic [NCH-1:0] ind_ci;
    logic [NCH-1:0] ind_mr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dch_arbiter #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .d_bits(d_bits),
        .chan_en(chan_en), .fsel_cnt(fsel_cnt), .susp_off(susp_off),
        .host_full(host_full), .ind_in_mr(ind_in_mr), .master_en(master_en),
        .rx_done(rx_done), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .ind_ci(ind_ci), .ind_mr(ind_mr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] oh(input int i);
        logic [NCH-1:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic frame(input logic [NCH-1:0] d);
        @(negedge clk);
        d_bits = d;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        d_bits = '1;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 grant_valid", 32'(grant_valid), 32'd0);
        check("R1 ind_ci", ind_ci, 32'd0);
        check("R1 ind_mr", ind_mr, 32'd0);
    endtask

    task automatic t_full_pick();
        frame(~(oh(5) | oh(9)));
        check("R2 grant_valid", 32'(grant_valid), 32'd1);
        check("R2 lowest idx", 32'(grant_idx), 32'd5);
        check("R3 only granted available", ind_ci, oh(5));
        check("R5 mr idle in ci mode", ind_mr, 32'd0);
    endtask

    task automatic t_hold_release();
        frame(~oh(2));
        check("R6 hold idx", 32'(grant_idx), 32'd5);
        pulse_done();
        repeat (3) @(negedge clk);
        check("R11 no release before strobe", 32'(grant_valid), 32'd1);
        check("R11 ind stable", ind_ci, oh(5));
        frame(~oh(2));
        check("R6 released", 32'(grant_valid), 32'd0);
        check("R3 idle all available", ind_ci, chan_en);
    endtask

    task automatic t_limited_count();
        frame(~oh(5));
        check("R7 last excluded f1", 32'(grant_valid), 32'd0);
        frame(~oh(5));
        check("R8 still limited f2", 32'(grant_valid), 32'd0);
        frame(~oh(5));
        check("R8 switch frame no grant f3", 32'(grant_valid), 32'd0);
        frame(~oh(5));
        check("R8 full after N+1", 32'(grant_valid), 32'd1);
        check("R8 idx", 32'(grant_idx), 32'd5);
        pulse_done();
        frame('1);
        frame(~(oh(5) | oh(7)));
        check("R7 other channel wins", 32'(grant_idx), 32'd7);
    endtask

    task automatic t_zero_count();
        fsel_cnt = 5'd0;
        pulse_done();
        frame('1);
        frame(~oh(7));
        check("R9 skip limited", 32'(grant_valid), 32'd1);
        check("R9 idx", 32'(grant_idx), 32'd7);
        pulse_done();
        chan_en[3] = 1'b0;
        frame('1);
        frame(~oh(3));
        check("R2 disabled ignored", 32'(grant_valid), 32'd0);
        check("R3 disabled reads 0", ind_ci, chan_en);
    endtask

    task automatic t_master_mr();
        master_en = 1'b0;
        frame(~oh(4));
        check("R4 grant", 32'(grant_idx), 32'd4);
        check("R4 all available", ind_ci, chan_en);
        ind_in_mr = 1'b1;
        frame('1);
        check("R5 mr carries", ind_mr, chan_en);
        check("R5 ci cleared", ind_ci, 32'd0);
        master_en = 1'b1;
        frame('1);
        check("R3 blocked via mr", ind_mr, oh(4));
        ind_in_mr = 1'b0;
    endtask

    task automatic t_suspend();
        fsel_cnt = 5'd1;
        susp_off = 1'b1;
        host_full = 1'b0;
        pulse_done();
        frame('1);
        for (int k = 0; k < 4; k++) begin
            frame(~oh(4));
            check("R10 counter frozen", 32'(grant_valid), 32'd0);
        end
        host_full = 1'b1;
        frame(~oh(4));
        check("R10 switch frame", 32'(grant_valid), 32'd0);
        frame(~oh(4));
        check("R10 host full grant", 32'(grant_valid), 32'd1);
        check("R10 idx", 32'(grant_idx), 32'd4);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_pick();
        t_hold_release();
        t_limited_count();
        t_zero_count();
        t_master_mr();
        t_suspend();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule